// File: doc/BRIEF.md
# Sequential Command Descriptor Loader

This block is the register front end that hands operation descriptors to a flash memory controller. Software builds a descriptor of three or four 32-bit words and pushes every word, one bus write at a time, to a single command address. An internal word pointer steers each accepted write into the next command buffer register. When the last word of the descriptor lands, the block raises a one-cycle launch strobe and keeps the assembled words, and a transfer byte count taken from the fourth word, steady on its outputs for the controller core to consume.

A configuration input picks three-word or four-word descriptors. In four-word mode the low 16 bits of the fourth word give an arbitrary transfer length for operations of non-standard size. In three-word mode that length output is held at zero so the controller falls back on its default length rules. A status register carries a write-command-request flag. The flag is raised while the controller reports idle and no load is under way, and software clears it by writing one to it. A load may only begin while the flag is set. A synchronous clear input abandons a partial load.

The command registers sit at their own addresses, and each can be read back there. Writes to any of those addresses other than the loading address are discarded.

Top module: `cmdbuf_loader`

## Requirements
- R1: After reset the word pointer is zero, all four command registers read zero, `wcr_flag` is 0 and `cmd_launch` is 0.
- R2: Word addresses are: 0 status, 1 command register 0 (the loading address), 2 command register 1, 3 command register 2, 4 command register 3. A read at addresses 1 to 4 returns that register's contents. Other addresses read as zero. `cmd_words` carries register k in bits [32k+31:32k].
- R3: With `four_word_mode` low, accepted writes to address 1 fill registers 0, 1 and 2 in turn. After the third word the pointer wraps, so the next accepted write lands in register 0 again.
- R4: With `four_word_mode` high, accepted writes to address 1 fill registers 0 to 3 in turn and then wrap to register 0.
- R5: `cmd_launch` is high for exactly one cycle, the cycle after the clock edge that captures the final word of a descriptor. It is low at all other times.
- R6: Bus writes to addresses 2, 3 and 4 change no command register.
- R7: `len_count` equals bits [15:0] of command register 3 while `four_word_mode` is high, and is zero while it is low.
- R8: The flag is bit 0 of the status register (address 0). It sets on a clock edge where `ctrl_idle` is high and the pointer is zero. A write to address 0 with data bit 0 set clears it. A write with bit 0 clear leaves it unchanged.
- R9: A write to address 1 is accepted only while the flag is set or a load is in progress (pointer not zero). Otherwise it is ignored. Accepting the first word of a descriptor clears the flag.
- R10: A cycle with `soft_clr` high zeroes all command registers and the pointer and suppresses `cmd_launch`. The next accepted word goes to register 0.
- R11: The command registers change only on an accepted write to address 1 or on `soft_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_clr | input | 1 | Synchronous clear of pointer and command registers |
| four_word_mode | input | 1 | 1 selects four-word descriptors, 0 selects three-word descriptors |
| ctrl_idle | input | 1 | Controller core is ready for a new command |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | 3 | Word address for reads and writes |
| bus_wdata | input | 32 | Bus write data |
| rd_data | output | 32 | Read data for `bus_addr` (combinational) |
| cmd_launch | output | 1 | One-cycle descriptor launch strobe |
| wcr_flag | output | 1 | Write-command-request status flag |
| len_count | output | 16 | Transfer length count from command register 3 |
| cmd_words | output | 128 | Assembled command registers 0 to 3 |

## Verification
The assertions assume that `four_word_mode` does not change while a descriptor is partly loaded. They also assume that the bus presents at most one write per cycle and that reads have no side effects. The stimulus changes the mode only when the pointer is zero, either after a launch or after `soft_clr`. It drives all inputs on the falling clock edge, so every write is a single clean cycle. The checks cover rejected loads, aliased writes, write-one-to-clear and a clear that arrives in the middle of a load, all within those assumptions.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;

   // word addresses of the register file
   localparam int unsigned ADDR_STATUS = 0;
   localparam int unsigned ADDR_CB0    = 1;
   localparam int unsigned ADDR_CB1    = 2;
   localparam int unsigned ADDR_CB2    = 3;
   localparam int unsigned ADDR_CB3    = 4;

   // status register bit carrying the write-command-request flag
   localparam int unsigned STAT_WCR_BIT = 0;

   // pointer width covers up to four descriptor words
   localparam int unsigned PTR_W = 2;

   typedef enum logic [2:0] {
      SEL_STATUS,
      SEL_CB0,
      SEL_CB1,
      SEL_CB2,
      SEL_CB3,
      SEL_NONE
   } regsel_e;

endpackage

// File: rtl/cmdbuf_decode.sv
module cmdbuf_decode
   import cmdbuf_pkg::*;
#(
   parameter int unsigned ADDR_W = 3
) (
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   output regsel_e           rd_sel,
   output logic              wr_status,
   output logic              wr_cb0
);

   always_comb begin
      if (bus_addr == ADDR_W'(ADDR_STATUS))      rd_sel = SEL_STATUS;
      else if (bus_addr == ADDR_W'(ADDR_CB0))    rd_sel = SEL_CB0;
      else if (bus_addr == ADDR_W'(ADDR_CB1))    rd_sel = SEL_CB1;
      else if (bus_addr == ADDR_W'(ADDR_CB2))    rd_sel = SEL_CB2;
      else if (bus_addr == ADDR_W'(ADDR_CB3))    rd_sel = SEL_CB3;
      else                                       rd_sel = SEL_NONE;
   end

   // only two addresses are writable; the other command addresses are read-only aliases
   assign wr_status = bus_wr && (rd_sel == SEL_STATUS);
   assign wr_cb0    = bus_wr && (rd_sel == SEL_CB0);

endmodule

// File: rtl/cmdbuf_seq.sv
module cmdbuf_seq
   import cmdbuf_pkg::*;
#(
   parameter int unsigned NWORDS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_clr,
   input  logic              wr_cb0,
   input  logic              wcr_flag,
   input  logic              four_mode,
   output logic [PTR_W-1:0]  ptr,
   output logic              first_accept,
   output logic [NWORDS-1:0] word_we,
   output logic              launch
);

   logic             accept;
   logic             at_last;
   logic [PTR_W-1:0] last_idx;

   assign last_idx     = (four_mode && (NWORDS > 3)) ? PTR_W'(3) : PTR_W'(2);
   assign accept       = wr_cb0 && !soft_clr && (wcr_flag || (ptr != '0));
   assign first_accept = accept && (ptr == '0);
   assign at_last      = (ptr >= last_idx);

   for (genvar i = 0; i < NWORDS; i++) begin : g_we
      assign word_we[i] = accept && (ptr == PTR_W'(i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr    <= '0;
         launch <= 1'b0;
      end else if (soft_clr) begin
         ptr    <= '0;
         launch <= 1'b0;
      end else begin
         launch <= accept && at_last;
         if (accept) begin
            ptr <= at_last ? '0 : ptr + 1'b1;
         end
      end
   end

endmodule

// File: rtl/cmdbuf_status.sv
module cmdbuf_status (
   input  logic clk,
   input  logic rst_n,
   input  logic ctrl_idle,
   input  logic ptr_zero,
   input  logic first_accept,
   input  logic w1c,
   output logic wcr_flag
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wcr_flag <= 1'b0;
      end else if (first_accept || w1c) begin
         wcr_flag <= 1'b0;
      end else if (ctrl_idle && ptr_zero) begin
         wcr_flag <= 1'b1;
      end
   end

endmodule

// File: rtl/cmdbuf_regs.sv
module cmdbuf_regs #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned NWORDS = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     soft_clr,
   input  logic [NWORDS-1:0]        word_we,
   input  logic [DATA_W-1:0]        wdata,
   output logic [NWORDS*DATA_W-1:0] words
);

   for (genvar i = 0; i < NWORDS; i++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            words[i*DATA_W +: DATA_W] <= '0;
         end else if (soft_clr) begin
            words[i*DATA_W +: DATA_W] <= '0;
         end else if (word_we[i]) begin
            words[i*DATA_W +: DATA_W] <= wdata;
         end
      end
   end

endmodule

// File: rtl/cmdbuf_loader.sv
module cmdbuf_loader
   import cmdbuf_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 3,
   parameter int unsigned LEN_W      = 16,
   parameter bit          HAS_FOURTH = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                soft_clr,
   input  logic                four_word_mode,
   input  logic                ctrl_idle,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   rd_data,
   output logic                cmd_launch,
   output logic                wcr_flag,
   output logic [LEN_W-1:0]    len_count,
   output logic [4*DATA_W-1:0] cmd_words
);

   localparam int unsigned NWORDS = HAS_FOURTH ? 4 : 3;

   if (LEN_W > DATA_W) begin : g_bad_len
      $error("cmdbuf_loader: LEN_W must not exceed DATA_W");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("cmdbuf_loader: ADDR_W must cover five word addresses");
   end
   if (DATA_W <= STAT_WCR_BIT) begin : g_bad_data
      $error("cmdbuf_loader: DATA_W too narrow for status bit");
   end

   regsel_e                  rd_sel;
   logic                     wr_status;
   logic                     wr_cb0;
   logic [PTR_W-1:0]         ptr;
   logic                     first_accept;
   logic [NWORDS-1:0]        word_we;
   logic [NWORDS*DATA_W-1:0] words;
   logic                     four_mode_eff;

   assign four_mode_eff = HAS_FOURTH && four_word_mode;

   cmdbuf_decode #(.ADDR_W(ADDR_W)) u_decode (
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .rd_sel    (rd_sel),
      .wr_status (wr_status),
      .wr_cb0    (wr_cb0)
   );

   cmdbuf_seq #(.NWORDS(NWORDS)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .soft_clr     (soft_clr),
      .wr_cb0       (wr_cb0),
      .wcr_flag     (wcr_flag),
      .four_mode    (four_mode_eff),
      .ptr          (ptr),
      .first_accept (first_accept),
      .word_we      (word_we),
      .launch       (cmd_launch)
   );

   cmdbuf_status u_status (
      .clk          (clk),
      .rst_n        (rst_n),
      .ctrl_idle    (ctrl_idle),
      .ptr_zero     (ptr == '0),
      .first_accept (first_accept),
      .w1c          (wr_status && bus_wdata[STAT_WCR_BIT]),
      .wcr_flag     (wcr_flag)
   );

   cmdbuf_regs #(.DATA_W(DATA_W), .NWORDS(NWORDS)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_clr (soft_clr),
      .word_we  (word_we),
      .wdata    (bus_wdata),
      .words    (words)
   );

   // variant choice: with a fourth register the length field is live, otherwise tied off
   if (HAS_FOURTH) begin : g_four
      assign cmd_words = words;
      assign len_count = four_mode_eff ? words[3*DATA_W +: LEN_W] : '0;
   end else begin : g_three
      assign cmd_words = {{DATA_W{1'b0}}, words};
      assign len_count = '0;
   end

   always_comb begin
      rd_data = '0;
      case (rd_sel)
         SEL_STATUS: rd_data[STAT_WCR_BIT] = wcr_flag;
         SEL_CB0:    rd_data = cmd_words[0*DATA_W +: DATA_W];
         SEL_CB1:    rd_data = cmd_words[1*DATA_W +: DATA_W];
         SEL_CB2:    rd_data = cmd_words[2*DATA_W +: DATA_W];
         SEL_CB3:    rd_data = cmd_words[3*DATA_W +: DATA_W];
         default:    rd_data = '0;
      endcase
   end

endmodule

// File: rtl/cmdbuf_loader_chk.sv
module cmdbuf_loader_chk
   import cmdbuf_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                soft_clr,
   input logic                four_word_mode,
   input logic                bus_wr,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [DATA_W-1:0]   bus_wdata,
   input logic                cmd_launch,
   input logic                wcr_flag,
   input logic [4*DATA_W-1:0] cmd_words,
   input logic [PTR_W-1:0]    ptr
);

   logic load_wr;
   assign load_wr = bus_wr && (bus_addr == ADDR_W'(ADDR_CB0));

   // R5
   launch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_launch |=> !cmd_launch);

   // R5
   launch_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_launch |-> $past(load_wr && !soft_clr));

   // R6
   alias_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !load_wr && !soft_clr) |=> $stable(cmd_words));

   // R8
   flag_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && (bus_addr == ADDR_W'(ADDR_STATUS)) && bus_wdata[STAT_WCR_BIT]) |=> !wcr_flag);

   // R9
   load_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_wr && !wcr_flag && (ptr == '0) && !soft_clr) |=> ($stable(cmd_words) && !cmd_launch));

   // R10
   soft_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_clr |=> ((cmd_words == '0) && !cmd_launch && (ptr == '0)));

   // R11
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_wr && !soft_clr) |=> $stable(cmd_words));

   // R3
   three_word_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !four_word_mode |-> (ptr <= PTR_W'(2)));

endmodule

bind cmdbuf_loader cmdbuf_loader_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .soft_clr       (soft_clr),
   .four_word_mode (four_word_mode),
   .bus_wr         (bus_wr),
   .bus_addr       (bus_addr),
   .bus_wdata      (bus_wdata),
   .cmd_launch     (cmd_launch),
   .wcr_flag       (wcr_flag),
   .cmd_words      (cmd_words),
   .ptr            (ptr)
);

// File: tb/tb_cmdbuf_loader.sv
module tb_cmdbuf_loader;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         soft_clr = 1'b0;
   logic         four_word_mode = 1'b0;
   logic         ctrl_idle = 1'b0;
   logic         bus_wr = 1'b0;
   logic [2:0]   bus_addr = '0;
   logic [31:0]  bus_wdata = '0;
   logic [31:0]  rd_data;
   logic         cmd_launch;
   logic         wcr_flag;
   logic [15:0]  len_count;
   logic [127:0] cmd_words;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #10 clk = ~clk;

   cmdbuf_loader dut (
      .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .four_word_mode(four_word_mode),
      .ctrl_idle(ctrl_idle), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .rd_data(rd_data), .cmd_launch(cmd_launch), .wcr_flag(wcr_flag),
      .len_count(len_count), .cmd_words(cmd_words)
   );

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // behavioural reference model
   int unsigned m_w[4];
   int          m_ptr = 0;
   bit          m_flag = 0;
   bit          m_launch = 0;

   always @(posedge clk) begin
      bit acc;
      bit w1c;
      int last;
      bit old_zero;
      if (!rst_n) begin
         foreach (m_w[i]) m_w[i] = 0;
         m_ptr = 0; m_flag = 0; m_launch = 0;
      end else begin
         old_zero = (m_ptr == 0);
         acc  = bus_wr && bus_addr == 3'd1 && !soft_clr && (m_flag || m_ptr != 0);
         w1c  = bus_wr && bus_addr == 3'd0 && bus_wdata[0];
         last = four_word_mode ? 3 : 2;
         if (acc && old_zero) m_flag = 0;
         else if (w1c) m_flag = 0;
         else if (ctrl_idle && old_zero) m_flag = 1;
         m_launch = 0;
         if (soft_clr) begin
            foreach (m_w[i]) m_w[i] = 0;
            m_ptr = 0;
         end else if (acc) begin
            m_w[m_ptr] = bus_wdata;
            if (m_ptr >= last) begin m_ptr = 0; m_launch = 1; end
            else m_ptr++;
         end
      end
      #5;
      if (rst_n && !done) begin
         logic [31:0] exp_rd;
         case (bus_addr)
            3'd0: exp_rd = {31'b0, m_flag};
            3'd1: exp_rd = m_w[0];
            3'd2: exp_rd = m_w[1];
            3'd3: exp_rd = m_w[2];
            3'd4: exp_rd = m_w[3];
            default: exp_rd = 0;
         endcase
         chk("R2 cmd_words model", cmd_words, {m_w[3], m_w[2], m_w[1], m_w[0]});
         chk("R2 rd_data model", rd_data, exp_rd);
         chk("R5 cmd_launch model", cmd_launch, m_launch);
         chk("R8 wcr_flag model", wcr_flag, m_flag);
         chk("R7 len_count model", len_count, four_word_mode ? m_w[3][15:0] : 16'h0);
      end
   end

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = 3'd0; bus_wdata = '0;
   endtask

   task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
      bus_addr = a;
      #1;
      chk(tag, rd_data, exp);
      bus_addr = 3'd0;
   endtask

   task automatic finish_up;
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL R5 watchdog actual=hung expected=finished");
      finish_up();
   end

   initial begin
      logic [127:0] snap;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 flag", wcr_flag, 0);
      chk("R1 launch", cmd_launch, 0);
      chk("R1 words", cmd_words, 0);

      // R9 load rejected while flag clear and no load in progress
      wr(3'd1, 32'h1111_1111);
      rd_chk("R9 rejected word", 3'd1, 32'h0);

      // R8 flag sets while idle
      ctrl_idle = 1'b1;
      @(negedge clk);
      chk("R8 flag set", wcr_flag, 1);
      wr(3'd0, 32'h0);
      chk("R8 write zero keeps flag", wcr_flag, 1);

      // R3 three-word descriptor
      four_word_mode = 1'b0;
      wr(3'd1, 32'hA000_000A);
      chk("R9 flag cleared by first word", wcr_flag, 0);
      wr(3'd1, 32'hB000_000B);
      wr(3'd1, 32'hC000_000C);
      chk("R3 R5 launch after third word", cmd_launch, 1);
      chk("R3 words", cmd_words[95:0], {32'hC000_000C, 32'hB000_000B, 32'hA000_000A});
      chk("R7 len zero in three-word mode", len_count, 16'h0);
      @(negedge clk);
      chk("R5 launch single cycle", cmd_launch, 0);

      // R6 aliased writes ignored
      wr(3'd2, 32'hDEAD_0001);
      wr(3'd3, 32'hDEAD_0002);
      wr(3'd4, 32'hDEAD_0003);
      rd_chk("R6 reg1 kept", 3'd2, 32'hB000_000B);
      rd_chk("R6 reg2 kept", 3'd3, 32'hC000_000C);
      rd_chk("R6 reg3 kept", 3'd4, 32'h0);

      // R4 four-word descriptor with length
      four_word_mode = 1'b1;
      wr(3'd1, 32'hD000_000D);
      wr(3'd1, 32'hE000_000E);
      wr(3'd1, 32'hF000_000F);
      chk("R4 no launch before fourth", cmd_launch, 0);
      wr(3'd1, 32'hABCD_1234);
      chk("R4 launch after fourth", cmd_launch, 1);
      chk("R7 len from reg3", len_count, 16'h1234);
      rd_chk("R2 reg3 readback", 3'd4, 32'hABCD_1234);
      @(negedge clk);
      four_word_mode = 1'b0;
      #1;
      chk("R7 len forced zero", len_count, 16'h0);

      // R8 write-one-to-clear, then R9 rejection
      ctrl_idle = 1'b0;
      @(negedge clk);
      wr(3'd0, 32'h1);
      chk("R8 w1c clears", wcr_flag, 0);
      wr(3'd1, 32'h5555_5555);
      rd_chk("R9 rejected after clear", 3'd1, 32'hD000_000D);

      // R10 soft clear mid-load
      ctrl_idle = 1'b1;
      four_word_mode = 1'b1;
      @(negedge clk);
      wr(3'd1, 32'h1234_0001);
      wr(3'd1, 32'h1234_0002);
      soft_clr = 1'b1;
      @(negedge clk);
      soft_clr = 1'b0;
      chk("R10 words zero", cmd_words, 0);
      chk("R10 no launch", cmd_launch, 0);
      @(negedge clk);
      wr(3'd1, 32'h7777_0001);
      rd_chk("R10 restart at reg0", 3'd1, 32'h7777_0001);
      rd_chk("R10 reg1 still zero", 3'd2, 32'h0);
      wr(3'd1, 32'h7777_0002);
      wr(3'd1, 32'h7777_0003);
      wr(3'd1, 32'h7777_0004);
      chk("R4 launch second descriptor", cmd_launch, 1);
      @(negedge clk);
      wr(3'd1, 32'h8888_0001);
      rd_chk("R4 wrap to reg0", 3'd1, 32'h8888_0001);
      rd_chk("R4 reg1 untouched by wrap", 3'd2, 32'h7777_0002);

      // R11 registers hold without writes
      snap = cmd_words;
      repeat (5) @(negedge clk);
      chk("R11 stable", cmd_words, snap);

      finish_up();
   end

endmodule